// File: doc/BRIEF.md
# Presettable Up/Down Counter with Limit Flag

This block is a synchronous binary counter of configurable width (eight bits by default). On every rising clock edge the counter can do one of five things: clear to zero, take a preset value from a parallel input, step up by one, step down by one, or hold. All of these are synchronous, and a fixed priority decides between them. Clear wins over load, and load wins over counting.

A combinational limit flag shows when the counter sits on the last state for the direction currently selected. That state is all ones when stepping up and all zeros when stepping down. A system can use the flag to end a count sequence, or to start an action at the end of a timed interval, without decoding the count value itself. The counter wraps around in both directions, so a modulus other than 2^WIDTH is obtained by reloading a start value when the flag is seen.

Top module: `updown_preset_counter`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, `count` becomes 0 after that edge, whatever `ld_en`, `cnt_en`, `up_dn` and `load_val` are.
- R2: When `clr_n` is high and `ld_en` is 1 at a rising edge, `count` takes the value `load_val` had at that edge.
- R3: When `clr_n` is high, `ld_en` is 0, `cnt_en` is 1 and `up_dn` is 1 (up), `count` increases by one on the edge, and all ones wraps to 0.
- R4: When `clr_n` is high, `ld_en` is 0, `cnt_en` is 1 and `up_dn` is 0 (down), `count` decreases by one on the edge, and 0 wraps to all ones.
- R5: When `clr_n` is high, `ld_en` is 0 and `cnt_en` is 0, `count` keeps its value across the edge, for any value of `up_dn` and `load_val`.
- R6: `at_limit` is 1 exactly when `up_dn` is 1 and `count` is all ones, or when `up_dn` is 0 and `count` is 0. It follows `count` and `up_dn` in the same cycle, and `cnt_en` has no effect on it.
- R7: When `ld_en` and `cnt_en` are both 1 with `clr_n` high, the load is taken and no step is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_en | input | 1 | Synchronous preset from `load_val` |
| cnt_en | input | 1 | Enables a step of one |
| up_dn | input | 1 | Step direction: 1 up, 0 down |
| load_val | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| at_limit | output | 1 | Count is at the last state for the current direction |

## Verification
The bound checker tests every edge after the first clear. It checks that each control combination leads to the matching next count: cleared, preset, stepped with modular wrap, or held. It also checks that the limit flag agrees with the count and the direction in every cycle. The bench scenarios cover the cases that a per-cycle property cannot select on its own purpose. These are the wrap points hit on purpose from each side, and all three controls raised in the same cycle. They also include the limit flag read while the direction changes and counting is disabled, and long random runs compared against an integer model.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_INC   = 3'd1,
        OP_DEC   = 3'd2,
        OP_PRESET = 3'd3,
        OP_ZERO  = 3'd4
    } cnt_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    ld_en,
    input  logic    cnt_en,
    input  logic    up_dn,
    output cnt_op_e op
);
    // Fixed priority: clear, then preset, then step, else hold.
    always_comb begin
        if (!clr_n)      op = OP_ZERO;
        else if (ld_en)  op = OP_PRESET;
        else if (cnt_en) op = up_dn ? OP_INC : OP_DEC;
        else             op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_step.sv
module cnt_step
    import cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (op)
            OP_ZERO:   nxt = '0;
            OP_PRESET: nxt = preset;
            OP_INC:    nxt = cur + ONE;   // modular wrap at all ones
            OP_DEC:    nxt = cur - ONE;   // modular wrap at zero
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_limit_detect.sv
module cnt_limit_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up_dn,
    output logic             hit
);
    logic all_ones;
    logic all_zero;

    assign all_ones = &cur;
    assign all_zero = ~|cur;
    assign hit      = up_dn ? all_ones : all_zero;
endmodule

// File: rtl/updown_preset_counter.sv
module updown_preset_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_en,
    input  logic             cnt_en,
    input  logic             up_dn,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             at_limit
);
    typedef struct packed {
        logic [WIDTH-1:0] value;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    cnt_op_e          op;
    logic [WIDTH-1:0] step_nxt;

    cnt_op_decode u_decode (
        .clr_n  (clr_n),
        .ld_en  (ld_en),
        .cnt_en (cnt_en),
        .up_dn  (up_dn),
        .op     (op)
    );

    cnt_step #(.WIDTH(WIDTH)) u_step (
        .op     (op),
        .cur    (state_q.value),
        .preset (load_val),
        .nxt    (step_nxt)
    );

    cnt_limit_detect #(.WIDTH(WIDTH)) u_limit (
        .cur   (state_q.value),
        .up_dn (up_dn),
        .hit   (at_limit)
    );

    always_comb begin
        state_d       = state_q;
        state_d.value = step_nxt;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.value;
endmodule

// File: rtl/updown_preset_counter_chk.sv
module updown_preset_counter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_en,
    input logic             cnt_en,
    input logic             up_dn,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] count,
    input logic             at_limit
);
    // Checks start only once a clear has given the count a known value.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> count == '0);

    assert_preset_R2: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_en) |=> count == $past(load_val));

    assert_inc_R3: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_en && cnt_en && up_dn) |=> count == WIDTH'($past(count) + 1'b1));

    assert_dec_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_en && cnt_en && !up_dn) |=> count == WIDTH'($past(count) - 1'b1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_en && !cnt_en) |=> $stable(count));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!armed_q)
        at_limit |-> (up_dn ? (count == {WIDTH{1'b1}}) : (count == '0)));

    assert_flag_clr_R6: assert property (@(posedge clk) disable iff (!armed_q)
        ((up_dn && count == {WIDTH{1'b1}}) || (!up_dn && count == '0)) |-> at_limit);

    assert_preset_wins_R7: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_en && cnt_en) |=> count == $past(load_val));
endmodule

bind updown_preset_counter updown_preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .ld_en    (ld_en),
    .cnt_en   (cnt_en),
    .up_dn    (up_dn),
    .load_val (load_val),
    .count    (count),
    .at_limit (at_limit)
);

// File: tb/updown_preset_counter_test.sv
`timescale 1ns/1ps
module updown_preset_counter_test;
    localparam int WIDTH = 8;
    localparam int MODV  = 1 << WIDTH;

    logic             clk = 1'b0;
    logic             clr_n = 1'b1;
    logic             ld_en = 1'b0;
    logic             cnt_en = 1'b0;
    logic             up_dn = 1'b1;
    logic [WIDTH-1:0] load_val = '0;
    logic [WIDTH-1:0] count;
    logic             at_limit;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    updown_preset_counter #(.WIDTH(WIDTH)) uut (
        .clk(clk), .clr_n(clr_n), .ld_en(ld_en), .cnt_en(cnt_en),
        .up_dn(up_dn), .load_val(load_val), .count(count), .at_limit(at_limit)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_flag(input int v, input bit dir);
        return dir ? (v == MODV - 1) : (v == 0);
    endfunction

    // Drive one cycle of controls, then compare the flag and the next count with the model.
    task automatic step(input bit c, input bit l, input bit e, input bit d,
                        input int v, input string req);
        @(negedge clk);
        clr_n = c; ld_en = l; cnt_en = e; up_dn = d; load_val = WIDTH'(v);
        #1;
        check("R6 flag", int'(at_limit), int'(exp_flag(model, d)));
        if (!c)      model = 0;
        else if (l)  model = v % MODV;
        else if (e)  model = d ? (model + 1) % MODV : (model + MODV - 1) % MODV;
        @(posedge clk);
        #1;
        check(req, int'(count), model);
    endtask

    function automatic string tag_of(input bit c, input bit l, input bit e, input bit d);
        if (!c)     return "R1 clear";
        if (l && e) return "R7 preset over step";
        if (l)      return "R2 preset";
        if (e)      return d ? "R3 up" : "R4 down";
        return "R5 hold";
    endfunction

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state through the synchronous clear
        step(0, 0, 0, 1, 0, "R1 clear from power-up");
        step(1, 0, 0, 1, 0, "R5 hold after clear");
        // R2 then R3 across the top wrap
        step(1, 1, 0, 1, 8'hFE, "R2 preset FE");
        step(1, 0, 1, 1, 0, "R3 up FE->FF");
        step(1, 0, 1, 1, 0, "R3 up wrap FF->00");
        step(1, 0, 1, 1, 0, "R3 up 00->01");
        // R4 across the bottom wrap
        step(1, 0, 1, 0, 0, "R4 down 01->00");
        step(1, 0, 1, 0, 0, "R4 down wrap 00->FF");
        step(1, 0, 1, 0, 0, "R4 down FF->FE");
        // R5 with disabled counting and noisy inputs
        step(1, 0, 0, 0, 8'h55, "R5 hold dir down");
        step(1, 0, 0, 1, 8'hAA, "R5 hold dir up");
        // R6: flag at both limits, direction toggled, counting disabled
        step(1, 1, 0, 1, 8'hFF, "R2 preset FF");
        step(1, 0, 0, 1, 0, "R6 hold at FF up");
        step(1, 0, 0, 0, 0, "R6 hold at FF down");
        step(1, 1, 0, 0, 0, "R2 preset 00");
        step(1, 0, 0, 0, 0, "R6 hold at 00 down");
        step(1, 0, 0, 1, 0, "R6 hold at 00 up");
        // R7 and R1 with every control raised together
        step(1, 1, 1, 1, 8'h3C, "R7 preset over up");
        step(1, 1, 1, 0, 8'h81, "R7 preset over down");
        step(0, 1, 1, 1, 8'h77, "R1 clear over preset and step");
        // Random run against the model
        for (int i = 0; i < 2000; i++) begin
            bit c, l, e, d;
            c = ($urandom % 16) != 0;
            l = ($urandom % 6) == 0;
            e = ($urandom % 4) != 0;
            d = ($urandom % 2) == 1;
            step(c, l, e, d, int'($urandom % MODV), tag_of(c, l, e, d));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule